// File: doc/BRIEF.md
# Two-Cycle Pipelined Byte ALU

This block is a small synchronous arithmetic and logic unit working on two 8-bit unsigned operands. A caller presents an operation code and both operands together with a one-cycle start strobe; the unit captures them on that rising clock edge. The result shows up on a 16-bit output port after a fixed two-cycle delay. Four operations are available: addition, unsigned multiplication, bitwise OR and bitwise AND. Each one fills only as many result bits as it needs, and the bits above that are zero.

The unit is fully pipelined. A strobe may arrive on every cycle, and results leave in the order they were issued. When no strobe arrives, the captured operands are held. The output then keeps showing the result of the last captured operation. A synchronous active-high reset empties the pipeline and drives the output to zero.

Top module: `alu8_pipe`

## Requirements
- R1: On a rising clock edge with `start` = 1 and `rst` = 0, the values of `op`, `a` and `b` are captured as one operation.
- R2: The result of an operation captured on edge N is on `res` just after edge N+2. Before that edge, `res` still shows the previous result.
- R3: `op` = 2'b00 gives `a + b` as a 9-bit sum with the carry in bit 8, and bits 15:9 are 0.
- R4: `op` = 2'b01 gives the unsigned 16-bit product `a * b`.
- R5: `op` = 2'b10 gives `a | b` in bits 7:0, and bits 15:8 are 0.
- R6: `op` = 2'b11 gives `a & b` in bits 7:0, and bits 15:8 are 0.
- R7: On an edge with `start` = 0, the inputs `op`, `a` and `b` are ignored and `res` keeps the result of the last captured operation.
- R8: An edge with `rst` = 1 clears every stage, so `res` is 0 after that edge. It stays 0 until a new captured operation reaches the output. Reset takes priority over `start`.
- R9: Strobes on consecutive cycles are each accepted, and their results appear on consecutive cycles in issue order.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for `op`, `a`, `b` |
| op | input | 2 | Operation code: 00 add, 01 multiply, 10 OR, 11 AND |
| a | input | 8 | First operand, unsigned |
| b | input | 8 | Second operand, unsigned |
| res | output | 16 | Zero-extended result, two cycles after capture |

## Verification
The hardest case to produce from the ports is an unbroken stream of strobes in which every slot must carry its own operation's result, exactly two cycles late. A latency off by one cycle still produces correct values, just in the wrong slot. The stimulus therefore issues a new operation on every cycle through a wide operand sweep of all four codes. It tracks the expected value of each slot in a three-deep model queue. Runs of idle cycles carry changing operands that must be ignored, and a reset lands in the middle of a live stream.

// File: rtl/alu8_pipe.sv
module alu8_pipe #(
  parameter int OPW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [OPW-1:0]       a,
  input  logic [OPW-1:0]       b,
  output logic [2*OPW-1:0]     res
);
  localparam int RW = 2 * OPW;

  logic [1:0]     cap_op;
  logic [OPW-1:0] cap_a, cap_b;
  logic [RW-1:0]  mid_q, out_q, calc;

  logic [OPW:0]   sum;
  logic [RW-1:0]  prod;

  assign sum  = {1'b0, cap_a} + {1'b0, cap_b};
  assign prod = RW'(cap_a) * RW'(cap_b);

  always_comb begin
    case (cap_op)
      2'b00:   calc = RW'(sum);
      2'b01:   calc = prod;
      2'b10:   calc = RW'(cap_a | cap_b);
      default: calc = RW'(cap_a & cap_b);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_op <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
      mid_q  <= '0;
      out_q  <= '0;
    end else begin
      if (start) begin
        cap_op <= op;
        cap_a  <= a;
        cap_b  <= b;
      end
      mid_q <= calc;
      out_q <= mid_q;
    end
  end

  assign res = out_q;
endmodule

module alu8_pipe_chk #(
  parameter int OPW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic [1:0]           op,
  input logic [OPW-1:0]       a,
  input logic [OPW-1:0]       b,
  input logic [2*OPW-1:0]     res
);
  localparam int RW = 2 * OPW;

  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  function automatic logic [RW-1:0] ref_f(input logic [1:0] o,
                                          input logic [OPW-1:0] x,
                                          input logic [OPW-1:0] y);
    case (o)
      2'b00:   ref_f = RW'(x) + RW'(y);
      2'b01:   ref_f = RW'(x) * RW'(y);
      2'b10:   ref_f = RW'(x | y);
      default: ref_f = RW'(x & y);
    endcase
  endfunction

  // R1 R2 R4 R9: every captured operation emerges exactly two cycles after capture
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd3 && $past(start, 3)) |->
      res == ref_f($past(op, 3), $past(a, 3), $past(b, 3)));

  a_r3_add_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd3 && $past(start, 3) && $past(op, 3) == 2'b00) |->
      res[RW-1:OPW+1] == '0);

  // R5 R6: logic results use only the low byte
  a_r5_logic_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd3 && $past(start, 3) && $past(op[1], 3)) |->
      res[RW-1:OPW] == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (warm >= 3'd4 && !$past(start, 3)) |-> $stable(res));

  a_r8_reset: assert property (@(posedge clk)
    rst |=> res == '0);
endmodule

bind alu8_pipe alu8_pipe_chk #(.OPW(OPW)) u_chk (.*);

// File: tb/alu8_pipe_test.sv
`timescale 1ns/1ps
module alu8_pipe_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [7:0]  a = 8'h00;
  logic [7:0]  b = 8'h00;
  logic [15:0] res;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  alu8_pipe uut (.clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b), .res(res));

  // {op, a, b, expected}
  localparam logic [33:0] VEC [0:11] = '{
    {2'b00, 8'hFF, 8'hFF, 16'h01FE},
    {2'b00, 8'h01, 8'h03, 16'h0004},
    {2'b00, 8'h80, 8'h80, 16'h0100},
    {2'b01, 8'hFF, 8'hFF, 16'hFE01},
    {2'b01, 8'h00, 8'hAB, 16'h0000},
    {2'b01, 8'h10, 8'h10, 16'h0100},
    {2'b01, 8'h0F, 8'h11, 16'h00FF},
    {2'b10, 8'hF0, 8'h0F, 16'h00FF},
    {2'b10, 8'hA5, 8'h00, 16'h00A5},
    {2'b11, 8'hFF, 8'hFF, 16'h00FF},
    {2'b11, 8'hA5, 8'h5A, 16'h0000},
    {2'b11, 8'h3C, 8'h0F, 16'h000C}
  };

  logic [15:0] e1, e2, e3, last;
  logic        v1, v2, v3;
  string       t1, t2, t3;

  function automatic logic [15:0] model(input logic [1:0] o, input logic [7:0] x, input logic [7:0] y);
    case (o)
      2'b00:   model = {7'd0, {1'b0, x} + {1'b0, y}};
      2'b01:   model = {8'd0, x} * {8'd0, y};
      2'b10:   model = {8'd0, x | y};
      default: model = {8'd0, x & y};
    endcase
  endfunction

  function automatic string optag(input logic [1:0] o);
    case (o)
      2'b00:   optag = "R3";
      2'b01:   optag = "R4";
      2'b10:   optag = "R5";
      default: optag = "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: res=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // One slot per cycle; the slot issued three negedges ago is visible now (R2, R9)
  task automatic step(input logic st, input logic [1:0] o, input logic [7:0] x,
                      input logic [7:0] y, input logic [15:0] ex, input string tg);
    @(negedge clk);
    if (v3) check(t3, res, e3);
    v3 = v2; e3 = e2; t3 = t2;
    v2 = v1; e2 = e1; t2 = t1;
    if (st) last = ex;
    v1 = 1'b1; e1 = last; t1 = st ? tg : "R7";
    start = st; op = o; a = x; b = y;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b1; op = 2'b01; a = 8'hFF; b = 8'hFF;
    @(negedge clk);
    check("R8", res, 16'h0000);
    rst = 1'b0; start = 1'b0;
    v1 = 1'b1; v2 = 1'b1; v3 = 1'b1;
    e1 = '0; e2 = '0; e3 = '0; last = '0;
    t1 = "R8"; t2 = "R8"; t3 = "R8";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    v1 = 0; v2 = 0; v3 = 0; e1 = 0; e2 = 0; e3 = 0; last = 0;
    t1 = ""; t2 = ""; t3 = "";
    repeat (3) @(negedge clk);
    check("R8", res, 16'h0000);
    do_reset();

    // R1 R3 R4 R5 R6: table of fixed vectors, issued back to back
    for (int i = 0; i < 12; i++)
      step(1'b1, VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], optag(VEC[i][33:32]));
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 8'h00, 8'h00, 16'h0, "R7");

    // R2 R9: a strobe every cycle across a wide operand sweep of all four codes
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 256; j++) begin
          logic [7:0] x;
          x = 8'(4 * i + (i % 4));
          step(1'b1, 2'(o), x, 8'(j), model(2'(o), x, 8'(j)), optag(2'(o)));
        end

    // R7: idle cycles with changing operands must not disturb the held result
    step(1'b1, 2'b01, 8'hFF, 8'hFE, 16'hFD02, "R4");
    for (int i = 0; i < 6; i++) step(1'b0, 2'(i), 8'(i * 37), 8'(255 - i), 16'h0, "R7");
    // R2: isolated op after idle — result appears only on its own slot
    step(1'b1, 2'b10, 8'h12, 8'h40, 16'h0052, "R5");
    step(1'b0, 2'b11, 8'hFF, 8'hFF, 16'h0, "R7");
    step(1'b1, 2'b00, 8'hFF, 8'h01, 16'h0100, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 2'b01, 8'h33, 8'h44, 16'h0, "R7");

    // R8: reset in a live stream, start held high during reset is ignored
    step(1'b1, 2'b01, 8'hC0, 8'h03, 16'h0240, "R4");
    step(1'b1, 2'b00, 8'h7F, 8'h7F, 16'h00FE, "R3");
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, 2'b01, 8'hFF, 8'hFF, 16'h0, "R8");
    step(1'b1, 2'b11, 8'hF3, 8'h3F, 16'h0033, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 8'h00, 8'h00, 16'h0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule